// File: doc/BRIEF.md
# Debounced Vectored Interrupt Collector

This block gathers sixteen interrupt sources, such as hand-operated switches or external signal lines. It turns each one into a clean request and offers the most urgent request to a processor as an 8-bit vector address. Each line first passes through a two-flop synchronizer. It then goes through a debounce filter that accepts a new level only after the line has held that level for a set number of sample ticks. The filter notices when the accepted level changes, in either direction. Each accepted change sets a pending flag for that line, and the flag stays set until the line is serviced.

The block picks one winner from the pending flags by fixed priority. Each line has its own vector, and software can rewrite that vector at any time through a small write port. A global enable, set and cleared by processor commands, decides whether a pending request reaches the processor. The processor accepts service only at an instruction boundary. Its acknowledge clears the pending flag of the line being offered in that cycle.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset `irqReq` is 0, `irqVector` is 0, interrupts are globally disabled and no line is pending.
- R2: A line's new level is accepted only after the synchronized input has differed from the accepted level on STABLE_TICKS consecutive sample ticks. A pulse seen on fewer ticks raises no request. A sample tick occurs once every TICK_DIV clock cycles.
- R3: Every accepted change of level, whether low-to-high or high-to-low, sets the pending flag of that line.
- R4: When several lines are pending, the one with the lowest index is offered. Line 0 has the highest priority.
- R5: A cycle with `vecWrEn` high stores `vecWrData` into the vector entry selected by `vecWrAddr`. After reset, entry i holds the value i.
- R6: `irqReq` is high only while interrupts are enabled and some line is pending. `enCmd` enables. `disCmd` disables, and it wins when both are high in the same cycle. Pending flags are kept while interrupts are disabled.
- R7: `irqVector` equals the vector entry of the offered line while `irqReq` is high, and 0 otherwise.
- R8: An acknowledge takes effect only when `ackIn`, `instrDone` and `irqReq` are all high in the same cycle. At that clock edge it clears the pending flag of the line offered in that cycle. An `ackIn` without `instrDone` changes nothing.
- R9: Further accepted changes on a line that is already pending merge into its single flag, so the line needs only one acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rawLines | input | NUM_LINES | Unfiltered interrupt sources |
| vecWrEn | input | 1 | Vector table write strobe |
| vecWrAddr | input | IDX_W | Vector table entry to write |
| vecWrData | input | VEC_W | Vector value to store |
| enCmd | input | 1 | Global enable command |
| disCmd | input | 1 | Global disable command |
| instrDone | input | 1 | Current instruction completes this cycle |
| ackIn | input | 1 | Processor takes the offered interrupt |
| irqReq | output | 1 | Request to the processor |
| irqVector | output | VEC_W | Vector address of the offered line |

## Verification
The bench builds the block with sixteen lines, 8-bit vectors, STABLE_TICKS = 3 and TICK_DIV = 2. These values keep a full debounce under ten cycles. They also let a glitch be held for exactly two sample ticks, one tick short of acceptance, while the tick divider is still exercised. With this small setup the bench can sweep every line in both edge directions against arithmetically computed vectors. It also covers every mirrored pair and every adjacent pair of lines for priority, as well as the enable, acknowledge and merge cases.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  // Strobes the control side issues to the datapath each cycle.
  typedef struct packed {
    logic sampleTick;   // debounce filters may sample this cycle
    logic clearWinner;  // drop the pending flag of the offered line
  } ctrl_strobe_t;
endpackage

// File: rtl/irq_line_filter.sv
module irq_line_filter #(
  parameter int STABLE_TICKS = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic sampleTick,
  input  logic rawIn,
  output logic changePulse
);
  localparam int CNT_W = (STABLE_TICKS > 1) ? $clog2(STABLE_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STABLE_TICKS - 1);

  logic [1:0]       syncQ;
  logic             stableQ;
  logic [CNT_W-1:0] cntQ;
  logic             changeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= '0;
      stableQ <= 1'b0;
      cntQ    <= '0;
      changeQ <= 1'b0;
    end else begin
      syncQ   <= {syncQ[0], rawIn};
      changeQ <= 1'b0;
      if (syncQ[1] == stableQ) begin
        cntQ <= '0;
      end else if (sampleTick) begin
        if (cntQ == LAST) begin
          stableQ <= syncQ[1];
          cntQ    <= '0;
          changeQ <= 1'b1;
        end else begin
          cntQ <= cntQ + 1'b1;
        end
      end
    end
  end

  assign changePulse = changeQ;

  // R2
  accept_after_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stableQ != $past(stableQ)) |-> ($past(cntQ) == LAST && $past(sampleTick)));

endmodule

// File: rtl/irq_vec_datapath.sv
module irq_vec_datapath
  import irq_vec_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int VEC_W     = 8,
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrl_strobe_t         strb,
  input  logic [NUM_LINES-1:0] changeVec,
  input  logic                 vecWrEn,
  input  logic [IDX_W-1:0]     vecWrAddr,
  input  logic [VEC_W-1:0]     vecWrData,
  input  logic                 reqActive,
  output logic                 anyPend,
  output logic [VEC_W-1:0]     irqVector
);
  logic [NUM_LINES-1:0] pendQ;
  logic [NUM_LINES-1:0] clearMask;
  logic [VEC_W-1:0]     vecTable [NUM_LINES];
  logic [IDX_W-1:0]     winIdx;

  always_comb begin
    winIdx = '0;
    for (int k = NUM_LINES - 1; k >= 0; k--) begin
      if (pendQ[k]) winIdx = IDX_W'(k);
    end
  end

  assign anyPend   = |pendQ;
  assign clearMask = strb.clearWinner ? (NUM_LINES'(1) << winIdx) : '0;
  assign irqVector = reqActive ? vecTable[winIdx] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
    end else begin
      pendQ <= (pendQ & ~clearMask) | changeVec;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_LINES; k++) vecTable[k] <= VEC_W'(k);
    end else if (vecWrEn && (int'(vecWrAddr) < NUM_LINES)) begin
      vecTable[vecWrAddr] <= vecWrData;
    end
  end

  // R4
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyPend |-> (pendQ[winIdx] && ((pendQ & ((NUM_LINES'(1) << winIdx) - 1'b1)) == '0)));

  generate
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_pend_chk
      // R8
      pend_clear_needs_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
        $fell(pendQ[g]) |-> $past(strb.clearWinner));
      // R9
      pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        (pendQ[g] && !clearMask[g]) |=> pendQ[g]);
    end
  endgenerate

endmodule

// File: rtl/irq_vec_control.sv
module irq_vec_control
  import irq_vec_pkg::*;
#(
  parameter int TICK_DIV = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         enCmd,
  input  logic         disCmd,
  input  logic         instrDone,
  input  logic         ackIn,
  input  logic         anyPend,
  output logic         irqReq,
  output ctrl_strobe_t strb
);
  logic enabledQ;
  logic tick;

  generate
    if (TICK_DIV <= 1) begin : g_tick_every
      assign tick = 1'b1;
    end else begin : g_tick_div
      localparam int DIV_W = $clog2(TICK_DIV);
      logic [DIV_W-1:0] divQ;
      always_ff @(posedge clk) begin
        if (!rstN)                            divQ <= '0;
        else if (divQ == DIV_W'(TICK_DIV - 1)) divQ <= '0;
        else                                   divQ <= divQ + 1'b1;
      end
      assign tick = (divQ == DIV_W'(TICK_DIV - 1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)       enabledQ <= 1'b0;
    else if (disCmd) enabledQ <= 1'b0;
    else if (enCmd)  enabledQ <= 1'b1;
  end

  assign irqReq           = enabledQ & anyPend;
  assign strb.sampleTick  = tick;
  assign strb.clearWinner = ackIn & instrDone & irqReq;

  // R6
  disable_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    disCmd |=> !irqReq);
  // R6
  enable_exposes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enCmd && !disCmd && anyPend && !strb.clearWinner) |=> irqReq);

endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irq_vec_pkg::*;
#(
  parameter int NUM_LINES    = 16,
  parameter int VEC_W        = 8,
  parameter int STABLE_TICKS = 4,
  parameter int TICK_DIV     = 4,
  localparam int IDX_W       = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] rawLines,
  input  logic                 vecWrEn,
  input  logic [IDX_W-1:0]     vecWrAddr,
  input  logic [VEC_W-1:0]     vecWrData,
  input  logic                 enCmd,
  input  logic                 disCmd,
  input  logic                 instrDone,
  input  logic                 ackIn,
  output logic                 irqReq,
  output logic [VEC_W-1:0]     irqVector
);
  ctrl_strobe_t         strb;
  logic [NUM_LINES-1:0] changeVec;
  logic                 anyPend;

  generate
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      irq_line_filter #(.STABLE_TICKS(STABLE_TICKS)) u_filt (
        .clk(clk), .rstN(rstN), .sampleTick(strb.sampleTick),
        .rawIn(rawLines[g]), .changePulse(changeVec[g]));
    end
  endgenerate

  irq_vec_control #(.TICK_DIV(TICK_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .enCmd(enCmd), .disCmd(disCmd),
    .instrDone(instrDone), .ackIn(ackIn), .anyPend(anyPend),
    .irqReq(irqReq), .strb(strb));

  irq_vec_datapath #(.NUM_LINES(NUM_LINES), .VEC_W(VEC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .changeVec(changeVec),
    .vecWrEn(vecWrEn), .vecWrAddr(vecWrAddr), .vecWrData(vecWrData),
    .reqActive(irqReq), .anyPend(anyPend), .irqVector(irqVector));

endmodule

// File: tb/sim_irq_vector_unit.sv
module sim_irq_vector_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 16;
  localparam int VW = 8;
  localparam int IW = 4;
  localparam int SETTLE = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NL-1:0] rawLines = '0;
  logic vecWrEn = 1'b0;
  logic [IW-1:0] vecWrAddr = '0;
  logic [VW-1:0] vecWrData = '0;
  logic enCmd = 1'b0, disCmd = 1'b0, instrDone = 1'b0, ackIn = 1'b0;
  logic irqReq;
  logic [VW-1:0] irqVector;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_unit #(.NUM_LINES(NL), .VEC_W(VW), .STABLE_TICKS(3), .TICK_DIV(2)) u0 (
    .clk(clk), .rstN(rstN), .rawLines(rawLines), .vecWrEn(vecWrEn),
    .vecWrAddr(vecWrAddr), .vecWrData(vecWrData), .enCmd(enCmd),
    .disCmd(disCmd), .instrDone(instrDone), .ackIn(ackIn),
    .irqReq(irqReq), .irqVector(irqVector));

  function automatic int vecOf(int i);
    return (i * 37 + 11) % 256;
  endfunction

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic toggle(int i);
    @(negedge clk);
    rawLines[i] = ~rawLines[i];
    cyc(SETTLE);
  endtask

  task automatic ack();
    @(negedge clk);
    ackIn = 1'b1; instrDone = 1'b1;
    @(negedge clk);
    ackIn = 1'b0; instrDone = 1'b0;
    cyc(1);
  endtask

  task automatic cmd(bit en, bit dis);
    @(negedge clk);
    enCmd = en; disCmd = dis;
    @(negedge clk);
    enCmd = 1'b0; disCmd = 1'b0;
    cyc(1);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    cyc(4);
    rstN = 1'b1;
    cyc(2);
    // R1 reset state
    chk("R1 req", irqReq, 0);
    chk("R1 vec", irqVector, 0);
    // R1 disabled after reset: a change raises no request
    toggle(3);
    chk("R1 disabled", irqReq, 0);
    cmd(1, 0);
    // R5 reset default entry 3 == 3; R3 rising edge
    chk("R3 rise req", irqReq, 1);
    chk("R5 default vec", irqVector, 3);
    ack();
    chk("R8 cleared", irqReq, 0);
    toggle(3);
    chk("R3 fall req", irqReq, 1);
    ack();
    // R2 glitch of 4 cycles = 2 ticks at TICK_DIV 2 is ignored
    @(negedge clk); rawLines[7] = 1'b1;
    cyc(4); rawLines[7] = 1'b0;
    cyc(SETTLE);
    chk("R2 glitch", irqReq, 0);
    // R5 program the table
    for (int i = 0; i < NL; i++) begin
      @(negedge clk);
      vecWrEn = 1'b1; vecWrAddr = IW'(i); vecWrData = VW'(vecOf(i));
    end
    @(negedge clk); vecWrEn = 1'b0;
    // R3/R5/R7/R8 sweep over every line, both directions
    for (int i = 0; i < NL; i++) begin
      for (int d = 0; d < 2; d++) begin
        toggle(i);
        chk("R3 sweep req", irqReq, 1);
        chk("R7 sweep vec", irqVector, vecOf(i));
        ack();
        chk("R8 sweep clr", irqReq, 0);
        chk("R7 idle vec", irqVector, 0);
      end
    end
    // R8 ack without instrDone ignored
    toggle(9);
    @(negedge clk); ackIn = 1'b1;
    @(negedge clk); ackIn = 1'b0;
    cyc(1);
    chk("R8 no boundary req", irqReq, 1);
    chk("R8 no boundary vec", irqVector, vecOf(9));
    ack();
    chk("R8 cleared", irqReq, 0);
    // R4 priority over mirrored and adjacent pairs
    for (int p = 0; p < 23; p++) begin
      int a, b;
      a = (p < 8) ? p : p - 8;
      b = (p < 8) ? NL - 1 - p : p - 7;
      @(negedge clk);
      rawLines[a] = ~rawLines[a]; rawLines[b] = ~rawLines[b];
      cyc(SETTLE);
      chk("R4 first", irqVector, vecOf(a < b ? a : b));
      ack();
      chk("R4 second", irqVector, vecOf(a < b ? b : a));
      ack();
      chk("R4 done", irqReq, 0);
    end
    // R6 disable hides, pending kept; R9 two edges merge
    cmd(0, 1);
    toggle(12);
    chk("R6 disabled", irqReq, 0);
    toggle(12);
    cmd(1, 0);
    chk("R6 kept", irqReq, 1);
    chk("R9 vec", irqVector, vecOf(12));
    ack();
    chk("R9 merged", irqReq, 0);
    // R6 both commands: disable wins
    toggle(2);
    chk("R6 pre", irqReq, 1);
    cmd(1, 1);
    chk("R6 both", irqReq, 0);
    cmd(1, 0);
    chk("R6 re-enable", irqReq, 1);
    ack();
    chk("R6 end", irqReq, 0);
    summary();
  end
endmodule